// File: doc/BRIEF.md
# GCM Counter, Tail and Tag Sequencer

This block runs one encrypt or decrypt pass of Galois/Counter Mode over a message that arrives as 128-bit blocks. At the start of a call it captures a 128-bit counter, a carried-in hash state, the hash key H, a length block, a byte count and two mode flags. For every data block it sends the current counter to an external block cipher and waits for the keystream. It XORs the keystream with the data and emits the result. It then folds the ciphertext into the hash state with a bit-serial GF(2^128) multiplier. Only the low 32 bits of the counter step.

A final block shorter than 16 bytes still uses one full counter value. Only the leading bytes of that block are produced, and the hashed block is zero padded. A call can be flagged as the last one. In that case the length block is hashed after the data, and the tag is made from a counter whose low word is forced to 1. When the flag is clear, the stepped counter and the hash state are left on the outputs so that a later call can carry on. The cipher sits outside the block behind a request/acknowledge pair, so any keyed function can stand in for it.

Top module: `gcm_seq`

## Requirements
- R1: Each data block uses the counter and then adds one to its low 32 bits, modulo 2^32. The upper 96 bits keep the value loaded at start for the whole call.
- R2: Block b of a call (b = 0, 1, ...) is XORed with the cipher output of {ctrIn[127:32], ctrIn[31:0]+b}. Byte 0 of a block is bits [127:120].
- R3: The block folded into the hash is the ciphertext: the produced output when decrypt=0 and the received input when decrypt=1. The fold is hash = (hash XOR block)·H in GCM bit order, where bit 127 is the coefficient of x^0.
- R4: If a call ends with n remaining bytes (1 to 15), that block still takes one counter value. dataOutBytes reads n, and output bytes n..15 are zero. The hashed block keeps ciphertext bytes 0..n-1 and has zeros after them, so input bytes past n have no effect on any output. dataOutBytes reads 16 for a full block.
- R5: With lastCall=1, the length block is XORed into the hash and multiplied by H after the data. The tag is then the hash XOR the cipher output of {ctr[127:32], 32'd1}, and it appears on tagOut when done is high.
- R6: With lastCall=0, ctrOut and hashOut hold the stepped counter and the hash state while done is high. Splitting a message at a 16-byte boundary across calls that chain these values gives the same tag as one call.
- R7: A call with byteCount=0 requests no data, produces no output and uses no data counter. It goes straight to the length and tag step, or to write-back.
- R8: cphReq stays high with cphBlock unchanged until cphAck is seen. The sequencer stalls for as long as the acknowledge takes.
- R9: done is high for exactly one cycle at the end of a call, and busy is low on the next cycle. After reset the block is idle with no request, ready or output strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a call; sampled while idle |
| decrypt | input | 1 | 1 = input is ciphertext |
| lastCall | input | 1 | 1 = hash the length block and form the tag |
| byteCount | input | CNT_W | Data bytes in this call |
| ctrIn | input | 128 | Counter for the first block |
| hashIn | input | 128 | Carried-in hash state |
| hashKey | input | 128 | Hash key H |
| lenBlock | input | 128 | Length block for the last call |
| dataIn | input | 128 | Input data block |
| dataInValid | input | 1 | dataIn holds a block |
| dataInReady | output | 1 | Block accepts dataIn this cycle |
| dataOut | output | 128 | Output data block |
| dataOutValid | output | 1 | One-cycle strobe for dataOut |
| dataOutBytes | output | 5 | Valid leading bytes of dataOut (1..16) |
| cphReq | output | 1 | Keystream request |
| cphBlock | output | 128 | Counter block sent to the cipher |
| cphAck | input | 1 | Keystream returned |
| cphKey | input | 128 | Cipher output for cphBlock |
| busy | output | 1 | A call is in progress |
| done | output | 1 | One-cycle end-of-call strobe |
| ctrOut | output | 128 | Current counter |
| hashOut | output | 128 | Current hash state |
| tagOut | output | 128 | Authentication tag |

## Verification
On every cycle the assertions check the following:
- the upper counter bits stay still during a call, and the low word steps by one with each output block;
- the padding bytes of a short output are zero and its byte count lies in range;
- a cipher request holds with a fixed counter until it is acknowledged;
- the block stays quiet while idle, and done lasts a single cycle.

The bench scenarios are the only check on the arithmetic. They cover the keystream XOR, the hashed ciphertext in both directions, the length fold and the tag, and the handling of the zero-length call. They also show that garbage past a short tail has no effect, that a decrypt of an encrypt returns the plaintext with the same tag, and that a message split across chained calls gives the same tag as a single call.

// File: rtl/gcm_seq_pkg.sv
package gcm_seq_pkg;
  localparam int BLK_W   = 128;
  localparam int BLK_BY  = BLK_W / 8;
  localparam int BCNT_W  = $clog2(BLK_BY) + 1;

  typedef enum logic [2:0] {
    S_IDLE, S_NEXT, S_DATA, S_KS, S_MUL, S_LMUL, S_TAG, S_FIN
  } seqState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic loadCfg;
    logic takeData;
    logic blockKs;
    logic lenMul;
    logic tagKs;
    logic tagSel;
  } dpCtl_t;

  // status from datapath to control
  typedef struct packed {
    logic noneLeft;
    logic lastSel;
    logic mulDone;
  } dpStat_t;
endpackage

// File: rtl/gcm_gf_mul.sv
module gcm_gf_mul
  import gcm_seq_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             load,
  input  logic [BLK_W-1:0] opA,
  input  logic [BLK_W-1:0] opB,
  output logic [BLK_W-1:0] prod,
  output logic             done
);
  localparam int SW = $clog2(BLK_W);
  localparam logic [SW-1:0] LAST = SW'(BLK_W - 1);
  localparam logic [BLK_W-1:0] POLY = {8'hE1, {(BLK_W-8){1'b0}}};

  logic [BLK_W-1:0] aReg, vReg, zReg;
  logic [SW-1:0]    stepCnt;
  logic             run;

  // one bit of opA per cycle, most significant (x^0) first
  always_ff @(posedge clk) begin
    if (!rstN) begin
      aReg    <= '0;
      vReg    <= '0;
      zReg    <= '0;
      stepCnt <= '0;
      run     <= 1'b0;
      done    <= 1'b0;
    end else begin
      done <= 1'b0;
      if (load) begin
        aReg    <= opA;
        vReg    <= opB;
        zReg    <= '0;
        stepCnt <= '0;
        run     <= 1'b1;
      end else if (run) begin
        if (aReg[BLK_W-1]) zReg <= zReg ^ vReg;
        vReg    <= (vReg >> 1) ^ (vReg[0] ? POLY : '0);
        aReg    <= aReg << 1;
        stepCnt <= stepCnt + 1'b1;
        if (stepCnt == LAST) begin
          run  <= 1'b0;
          done <= 1'b1;
        end
      end
    end
  end

  assign prod = zReg;
endmodule

// File: rtl/gcm_seq_ctrl.sv
module gcm_seq_ctrl
  import gcm_seq_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    start,
  input  logic    dataInValid,
  input  logic    cphAck,
  input  dpStat_t stat,
  output dpCtl_t  ctl,
  output logic    dataInReady,
  output logic    cphReq,
  output logic    busy,
  output logic    done
);
  seqState_t st, nxt;

  always_ff @(posedge clk) begin
    if (!rstN) st <= S_IDLE;
    else       st <= nxt;
  end

  always_comb begin
    nxt         = st;
    ctl         = '0;
    dataInReady = 1'b0;
    cphReq      = 1'b0;
    unique case (st)
      S_IDLE: if (start) begin
        ctl.loadCfg = 1'b1;
        nxt         = S_NEXT;
      end
      S_NEXT: begin
        if (!stat.noneLeft) nxt = S_DATA;
        else if (stat.lastSel) begin
          ctl.lenMul = 1'b1;
          nxt        = S_LMUL;
        end else nxt = S_FIN;
      end
      S_DATA: begin
        dataInReady = 1'b1;
        if (dataInValid) begin
          ctl.takeData = 1'b1;
          nxt          = S_KS;
        end
      end
      S_KS: begin
        cphReq = 1'b1;
        if (cphAck) begin
          ctl.blockKs = 1'b1;
          nxt         = S_MUL;
        end
      end
      S_MUL:  if (stat.mulDone) nxt = S_NEXT;
      S_LMUL: if (stat.mulDone) nxt = S_TAG;
      S_TAG: begin
        cphReq     = 1'b1;
        ctl.tagSel = 1'b1;
        if (cphAck) begin
          ctl.tagKs = 1'b1;
          nxt       = S_FIN;
        end
      end
      S_FIN:  nxt = S_IDLE;
      default: nxt = S_IDLE;
    endcase
  end

  assign busy = (st != S_IDLE);
  assign done = (st == S_FIN);
endmodule

// File: rtl/gcm_seq_dp.sv
module gcm_seq_dp
  import gcm_seq_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int INC_W = 32
)(
  input  logic              clk,
  input  logic              rstN,
  input  dpCtl_t            ctl,
  output dpStat_t           stat,
  input  logic              decrypt,
  input  logic              lastCall,
  input  logic [CNT_W-1:0]  byteCount,
  input  logic [BLK_W-1:0]  ctrIn,
  input  logic [BLK_W-1:0]  hashIn,
  input  logic [BLK_W-1:0]  hashKey,
  input  logic [BLK_W-1:0]  lenBlock,
  input  logic [BLK_W-1:0]  dataIn,
  input  logic [BLK_W-1:0]  cphKey,
  output logic [BLK_W-1:0]  cphBlock,
  output logic [BLK_W-1:0]  dataOut,
  output logic              dataOutValid,
  output logic [BCNT_W-1:0] dataOutBytes,
  output logic [BLK_W-1:0]  ctrOut,
  output logic [BLK_W-1:0]  hashOut,
  output logic [BLK_W-1:0]  tagOut
);
  localparam logic [BCNT_W-1:0] FULL = BCNT_W'(BLK_BY);

  logic              decR, lastR;
  logic [CNT_W-1:0]  bytesLeft;
  logic [BLK_W-1:0]  keyR, lenR, ctrR, hashR, dataR, outR, tagR;
  logic              outVR;
  logic [BCNT_W-1:0] outBytesR, take;
  logic [BLK_W-1:0]  byteMask, ksOut, ctBlk, mulA, mulProd;
  logic              mulDone;

  assign take = (bytesLeft >= CNT_W'(BLK_BY)) ? FULL : bytesLeft[BCNT_W-1:0];

  // keep leading bytes only, byte 0 in the top bits
  for (genvar i = 0; i < BLK_BY; i++) begin : g_mask
    assign byteMask[BLK_W-1-8*i -: 8] = {8{(BCNT_W'(i) < take)}};
  end

  assign ksOut = (dataR ^ cphKey) & byteMask;
  assign ctBlk = decR ? (dataR & byteMask) : ksOut;
  assign mulA  = hashR ^ (ctl.lenMul ? lenR : ctBlk);

  gcm_gf_mul u_mul (
    .clk  (clk),
    .rstN (rstN),
    .load (ctl.blockKs | ctl.lenMul),
    .opA  (mulA),
    .opB  (keyR),
    .prod (mulProd),
    .done (mulDone)
  );

  always_ff @(posedge clk) begin
    if (!rstN) begin
      decR      <= 1'b0;
      lastR     <= 1'b0;
      bytesLeft <= '0;
      keyR      <= '0;
      lenR      <= '0;
      ctrR      <= '0;
      hashR     <= '0;
      dataR     <= '0;
      outR      <= '0;
      outVR     <= 1'b0;
      outBytesR <= '0;
      tagR      <= '0;
    end else begin
      outVR <= 1'b0;
      if (ctl.loadCfg) begin
        decR      <= decrypt;
        lastR     <= lastCall;
        bytesLeft <= byteCount;
        keyR      <= hashKey;
        lenR      <= lenBlock;
        ctrR      <= ctrIn;
        hashR     <= hashIn;
      end
      if (ctl.takeData) dataR <= dataIn;
      if (ctl.blockKs) begin
        outR      <= ksOut;
        outVR     <= 1'b1;
        outBytesR <= take;
        bytesLeft <= bytesLeft - CNT_W'(take);
        ctrR[INC_W-1:0] <= ctrR[INC_W-1:0] + 1'b1;
      end
      if (mulDone)   hashR <= mulProd;
      if (ctl.tagKs) tagR  <= hashR ^ cphKey;
    end
  end

  assign cphBlock      = ctl.tagSel ? {ctrR[BLK_W-1:INC_W], INC_W'(1)} : ctrR;
  assign dataOut       = outR;
  assign dataOutValid  = outVR;
  assign dataOutBytes  = outBytesR;
  assign ctrOut        = ctrR;
  assign hashOut       = hashR;
  assign tagOut        = tagR;
  assign stat.noneLeft = (bytesLeft == '0);
  assign stat.lastSel  = lastR;
  assign stat.mulDone  = mulDone;
endmodule

// File: rtl/gcm_seq.sv
module gcm_seq
  import gcm_seq_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int INC_W = 32
)(
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic              decrypt,
  input  logic              lastCall,
  input  logic [CNT_W-1:0]  byteCount,
  input  logic [BLK_W-1:0]  ctrIn,
  input  logic [BLK_W-1:0]  hashIn,
  input  logic [BLK_W-1:0]  hashKey,
  input  logic [BLK_W-1:0]  lenBlock,
  input  logic [BLK_W-1:0]  dataIn,
  input  logic              dataInValid,
  output logic              dataInReady,
  output logic [BLK_W-1:0]  dataOut,
  output logic              dataOutValid,
  output logic [BCNT_W-1:0] dataOutBytes,
  output logic              cphReq,
  output logic [BLK_W-1:0]  cphBlock,
  input  logic              cphAck,
  input  logic [BLK_W-1:0]  cphKey,
  output logic              busy,
  output logic              done,
  output logic [BLK_W-1:0]  ctrOut,
  output logic [BLK_W-1:0]  hashOut,
  output logic [BLK_W-1:0]  tagOut
);
  dpCtl_t  ctl;
  dpStat_t stat;

  gcm_seq_ctrl u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .start       (start),
    .dataInValid (dataInValid),
    .cphAck      (cphAck),
    .stat        (stat),
    .ctl         (ctl),
    .dataInReady (dataInReady),
    .cphReq      (cphReq),
    .busy        (busy),
    .done        (done)
  );

  gcm_seq_dp #(.CNT_W(CNT_W), .INC_W(INC_W)) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .ctl          (ctl),
    .stat         (stat),
    .decrypt      (decrypt),
    .lastCall     (lastCall),
    .byteCount    (byteCount),
    .ctrIn        (ctrIn),
    .hashIn       (hashIn),
    .hashKey      (hashKey),
    .lenBlock     (lenBlock),
    .dataIn       (dataIn),
    .cphKey       (cphKey),
    .cphBlock     (cphBlock),
    .dataOut      (dataOut),
    .dataOutValid (dataOutValid),
    .dataOutBytes (dataOutBytes),
    .ctrOut       (ctrOut),
    .hashOut      (hashOut),
    .tagOut       (tagOut)
  );
endmodule

// File: rtl/gcm_seq_chk.sv
module gcm_seq_chk
  import gcm_seq_pkg::*;
#(
  parameter int INC_W = 32
)(
  input logic              clk,
  input logic              rstN,
  input logic              busy,
  input logic              done,
  input logic              dataInReady,
  input logic              dataOutValid,
  input logic [BCNT_W-1:0] dataOutBytes,
  input logic [BLK_W-1:0]  dataOut,
  input logic [BLK_W-1:0]  ctrOut,
  input logic              cphReq,
  input logic              cphAck,
  input logic [BLK_W-1:0]  cphBlock
);
  p_upper_fixed_r1: assert property (@(posedge clk) disable iff (!rstN)
    (busy && $past(busy)) |-> $stable(ctrOut[BLK_W-1:INC_W]));

  p_low_step_r1: assert property (@(posedge clk) disable iff (!rstN)
    dataOutValid |-> ctrOut[INC_W-1:0] == INC_W'($past(ctrOut[INC_W-1:0]) + 1'b1));

  p_bytes_range_r4: assert property (@(posedge clk) disable iff (!rstN)
    dataOutValid |-> (dataOutBytes != '0) && (dataOutBytes <= BCNT_W'(BLK_BY)));

  p_tail_zero_r4: assert property (@(posedge clk) disable iff (!rstN)
    (dataOutValid && dataOutBytes < BCNT_W'(BLK_BY)) |->
      ((dataOut << (8 * dataOutBytes)) == '0));

  p_req_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    (cphReq && !cphAck) |=> (cphReq && $stable(cphBlock)));

  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rstN)
    done |=> (!done && !busy));

  p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (!cphReq && !dataInReady && !dataOutValid));
endmodule

bind gcm_seq gcm_seq_chk #(.INC_W(INC_W)) u_chk (.*);

// File: tb/gcm_seq_tb.sv
module gcm_seq_tb;
  localparam int CNT_W = 16;
  localparam logic [127:0] HKEY = 128'h66e94bd4ef8a2c3b884cfa59ca342b2e;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic         rstN, start, decrypt, lastCall, dataInValid, cphAck;
  logic [CNT_W-1:0] byteCount;
  logic [127:0] ctrIn, hashIn, hashKey, lenBlock, dataIn, cphKey;
  logic         dataInReady, dataOutValid, cphReq, busy, done;
  logic [4:0]   dataOutBytes;
  logic [127:0] dataOut, cphBlock, ctrOut, hashOut, tagOut;

  gcm_seq #(.CNT_W(CNT_W)) u_dut (
    .clk(clk), .rstN(rstN), .start(start), .decrypt(decrypt), .lastCall(lastCall),
    .byteCount(byteCount), .ctrIn(ctrIn), .hashIn(hashIn), .hashKey(hashKey),
    .lenBlock(lenBlock), .dataIn(dataIn), .dataInValid(dataInValid),
    .dataInReady(dataInReady), .dataOut(dataOut), .dataOutValid(dataOutValid),
    .dataOutBytes(dataOutBytes), .cphReq(cphReq), .cphBlock(cphBlock),
    .cphAck(cphAck), .cphKey(cphKey), .busy(busy), .done(done),
    .ctrOut(ctrOut), .hashOut(hashOut), .tagOut(tagOut)
  );

  int tests = 0, fails = 0;
  int rspDelay = 0, waitCnt = 0, reqDrops = 0;
  logic [7:0]   inBytes [0:63];
  logic [7:0]   outMem  [0:63];
  logic [7:0]   plain   [0:63];
  logic [127:0] lastTag, lastCtr, lastHash;

  task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [127:0] gfMul(input logic [127:0] x, input logic [127:0] y);
    logic [127:0] z = '0, v = y;
    for (int i = 0; i < 128; i++) begin
      if (x[127-i]) z ^= v;
      v = v[0] ? ((v >> 1) ^ {8'hE1, 120'd0}) : (v >> 1);
    end
    return z;
  endfunction

  // stand-in cipher
  function automatic logic [127:0] ksFn(input logic [127:0] b);
    return {b[95:0], b[127:96]} ^ {b[63:0], b[127:64]} ^ {4{32'h9E3779B9}} ^ (b >> 3);
  endfunction

  // cipher responder with a programmable stall
  initial begin
    cphAck = 1'b0;
    cphKey = '0;
    forever begin
      @(negedge clk);
      if (cphAck) cphAck = 1'b0;
      else if (cphReq) begin
        if (waitCnt >= rspDelay) begin
          cphAck  = 1'b1;
          cphKey  = ksFn(cphBlock);
          waitCnt = 0;
        end else waitCnt++;
      end else if (waitCnt != 0) begin
        reqDrops++;
        waitCnt = 0;
      end
    end
  end

  task automatic fillMsg(input int n, input int seed);
    for (int j = 0; j < 64; j++)
      inBytes[j] = (j < n) ? 8'(j * 37 + seed) : 8'(8'hC3 ^ j);
  endtask

  task automatic runCall(input bit dec, input bit last, input int n,
                         input logic [127:0] c, input logic [127:0] h, input string tg);
    logic [127:0] expOut [0:3];
    int           expTake [0:3];
    logic [127:0] hh, ctB, k, inBlk, ob, lenB, expTag, expCtr;
    int nb, got;
    bit gotDone;
    nb   = (n + 15) / 16;
    hh   = h;
    lenB = {64'd136, 64'(n * 8)};
    for (int b = 0; b < nb; b++) begin
      k  = ksFn({c[127:32], c[31:0] + 32'(b)});
      expTake[b] = (n - 16*b >= 16) ? 16 : n - 16*b;
      ob  = '0;
      ctB = '0;
      for (int i = 0; i < 16; i++) begin
        if (i < expTake[b]) begin
          ob[127-8*i -: 8]  = inBytes[16*b+i] ^ k[127-8*i -: 8];
          ctB[127-8*i -: 8] = dec ? inBytes[16*b+i] : ob[127-8*i -: 8];
        end
      end
      expOut[b] = ob;
      hh = gfMul(hh ^ ctB, HKEY);
    end
    if (last) hh = gfMul(hh ^ lenB, HKEY);
    expTag = hh ^ ksFn({c[127:32], 32'd1});
    expCtr = {c[127:32], c[31:0] + 32'(nb)};

    @(negedge clk);
    decrypt = dec; lastCall = last; byteCount = CNT_W'(n);
    ctrIn = c; hashIn = h; hashKey = HKEY; lenBlock = lenB;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    got = 0;
    gotDone = 0;
    fork
      begin
        for (int b = 0; b < nb; b++) begin
          for (int i = 0; i < 16; i++) inBlk[127-8*i -: 8] = inBytes[16*b+i];
          dataIn = inBlk;
          dataInValid = 1'b1;
          while (!dataInReady) @(negedge clk);
          @(negedge clk);
          dataInValid = 1'b0;
        end
      end
      begin
        while (!gotDone) begin
          if (dataOutValid) begin
            if (got < nb) begin
              chk(dataOut == expOut[got], {tg, " R2 R3 R4 data block"}, dataOut, expOut[got]);
              chk(dataOutBytes == 5'(expTake[got]), {tg, " R4 byte count"},
                  128'(dataOutBytes), 128'(expTake[got]));
              for (int i = 0; i < 16; i++) outMem[16*got+i] = dataOut[127-8*i -: 8];
            end
            got++;
          end
          if (done) begin
            gotDone = 1;
            if (last) chk(tagOut == expTag, {tg, " R5 tag"}, tagOut, expTag);
            else begin
              chk(ctrOut == expCtr, {tg, " R1 R6 counter write-back"}, ctrOut, expCtr);
              chk(hashOut == hh, {tg, " R6 hash write-back"}, hashOut, hh);
            end
            lastTag = tagOut; lastCtr = ctrOut; lastHash = hashOut;
          end
          @(negedge clk);
        end
      end
    join
    chk(!done && !busy, {tg, " R9 done single cycle"}, 128'({done, busy}), 128'(0));
    chk(got == nb, {tg, " R7 output block count"}, 128'(got), 128'(nb));
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL R9 watchdog expired actual=hung expected=finished");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [127:0] c0, tagA;
    rstN = 1'b0; start = 1'b0; decrypt = 1'b0; lastCall = 1'b0; byteCount = '0;
    ctrIn = '0; hashIn = '0; hashKey = '0; lenBlock = '0; dataIn = '0; dataInValid = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk(!busy && !done && !cphReq && !dataInReady && !dataOutValid, "R9 reset idle",
        128'({busy, done, cphReq, dataInReady, dataOutValid}), 128'(0));

    c0 = 128'h0123456789abcdef_fedcba98_00000002;
    // sweep every length 0..40 both directions, last call, varied stall
    for (int n = 0; n <= 40; n++) begin
      rspDelay = n % 4;
      fillMsg(n, n);
      runCall(1'b0, 1'b1, n, c0 ^ 128'(n << 40), 128'h0, "enc sweep");
      runCall(1'b1, 1'b1, n, c0 ^ 128'(n << 40), 128'h0, "dec sweep");
    end
    // write-back sweep with a carried-in hash
    for (int n = 0; n <= 40; n++) begin
      rspDelay = (n * 3) % 5;
      fillMsg(n, 7 * n);
      runCall(1'b0, 1'b0, n, c0, 128'h5a5a_0000_1111_2222_3333_4444_5555_6666, "wb sweep");
    end

    // R1 wrap of the low word
    rspDelay = 1;
    fillMsg(48, 3);
    runCall(1'b0, 1'b0, 48, 128'hdeadbeef_00112233_44556677_fffffffe, 128'h0, "R1 wrap");
    chk(lastCtr == 128'hdeadbeef_00112233_44556677_00000001, "R1 wrap upper kept",
        lastCtr, 128'hdeadbeef_00112233_44556677_00000001);

    // R3 round trip: decrypt of the encryption returns plaintext and same tag
    fillMsg(37, 11);
    for (int j = 0; j < 64; j++) plain[j] = inBytes[j];
    runCall(1'b0, 1'b1, 37, c0, 128'h0, "R3 enc");
    tagA = lastTag;
    for (int j = 0; j < 64; j++) inBytes[j] = (j < 37) ? outMem[j] : 8'(8'h3C ^ j);
    runCall(1'b1, 1'b1, 37, c0, 128'h0, "R3 dec");
    for (int j = 0; j < 37; j++)
      chk(outMem[j] == plain[j], "R3 round trip plaintext", 128'(outMem[j]), 128'(plain[j]));
    chk(lastTag == tagA, "R3 round trip tag", lastTag, tagA);

    // R6 split across calls equals a single call
    rspDelay = 2;
    fillMsg(45, 21);
    runCall(1'b0, 1'b1, 45, c0, 128'h0, "R6 single");
    tagA = lastTag;
    runCall(1'b0, 1'b0, 32, c0, 128'h0, "R6 part one");
    for (int j = 0; j < 32; j++) inBytes[j] = inBytes[j+32];
    begin
      logic [127:0] cc, hc;
      cc = lastCtr; hc = lastHash;
      // length block must describe the whole message
      runCallSplitTail(cc, hc);
    end
    chk(lastTag == tagA, "R6 split tag equals single", lastTag, tagA);

    chk(reqDrops == 0, "R8 request held until acknowledge", 128'(reqDrops), 128'(0));

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  // final 13 bytes of the 45-byte message, length block of the whole message
  task automatic runCallSplitTail(input logic [127:0] c, input logic [127:0] h);
    int got;
    bit gotDone;
    @(negedge clk);
    decrypt = 1'b0; lastCall = 1'b1; byteCount = CNT_W'(13);
    ctrIn = c; hashIn = h; hashKey = HKEY; lenBlock = {64'd136, 64'(45 * 8)};
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    got = 0;
    gotDone = 0;
    fork
      begin
        logic [127:0] blk;
        for (int i = 0; i < 16; i++) blk[127-8*i -: 8] = inBytes[i];
        dataIn = blk;
        dataInValid = 1'b1;
        while (!dataInReady) @(negedge clk);
        @(negedge clk);
        dataInValid = 1'b0;
      end
      begin
        while (!gotDone) begin
          if (dataOutValid) got++;
          if (done) begin
            gotDone = 1;
            lastTag = tagOut;
          end
          @(negedge clk);
        end
      end
    join
    chk(got == 1, "R4 R6 split tail one block", 128'(got), 128'(1));
  endtask
endmodule